// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Host Timing Engine

This block sits on the host side of a parallel ATA cable and runs one programmed-I/O register or data cycle at a time. A local requester hands it a drive address, a direction, write data, a wish for a 16-bit transfer and a timing mode (0, 1 or 2). The engine then drives the address lines and write data, asserts the read or write strobe, and negates it. It captures read data on the negation edge, keeps the address valid for the hold time, and waits out the rest of the mode's minimum cycle before it reports completion.

All delays are whole cycles of one system clock. Each nanosecond minimum is turned into a cycle count at elaboration: the count is the nanosecond value divided by the clock period `CLK_NS`, rounded up. Two inputs from the drive shape the cycle. The 16-bit-capable signal (active low) is sampled on the edge that asserts the strobe. If it is asserted and the requester asked for 16 bits, the short 16-bit pulse is used. Otherwise the long 8-bit pulse is used. The ready signal is sampled shortly after the strobe asserts. If it is low there, the strobe is held until the drive releases it, or until a timeout ends the cycle with an error flag.

Top module: `pio_host_engine`

## Requirements
- R1: While reset is held and after it is released, the engine shows `req_ready`=1, both strobes high (negated), `ata_addr_oe`=0, `ata_doe`=0, and `done` and `timeout` at 0.
- R2: A request is taken on the edge where `req_valid` is 1 in idle. The address is driven from the next cycle. The strobe asserts exactly S cycles after acceptance, where S = ceil(setup_ns/CLK_NS) and setup_ns is 90, 50 or 40 for modes 0, 1 and 2. Only `ata_rd_n` pulses on a read (`req_write`=0), and only `ata_wr_n` pulses on a write.
- R3: `ata_iocs16_n` is sampled on the edge that asserts the strobe. The transfer is 16-bit (`xfer_wide`=1) only if `req_wide`=1 and that sample is 0. The strobe stays low for ceil(pulse_ns/CLK_NS) cycles: pulse_ns is 165, 125 or 100 ns for 16-bit in modes 0, 1 and 2, and 290 ns for 8-bit in every mode.
- R4: `ata_iordy` is sampled on the edge ending the strobe's ceil(35/CLK_NS)-th low cycle. If it is 0 there, the strobe is negated on the first edge, no earlier than the minimum width, at which `ata_iordy` is 1. A low level seen only on later edges has no effect.
- R5: If the ready signal was low at its sample and stays low, the strobe is negated on the edge ceil(1250/CLK_NS) cycles after the sample edge. That transfer's `done` pulse carries `timeout`=1. A release seen on that very edge gives a normal end with `timeout`=0.
- R6: On a read, `rdata` takes `ata_din` on the strobe-negation edge. For an 8-bit transfer, the upper half of `rdata` is zero. A write leaves `rdata` unchanged.
- R7: After negation, the address and (on writes) the data stay driven and unchanged for H = ceil(hold_ns/CLK_NS) cycles, where hold_ns is 30, 20 or 15 ns. They are then released.
- R8: `done` is a one-cycle pulse at max(S+P+H, ceil(cycle_ns/CLK_NS)) cycles after acceptance, where P is the actual strobe width and cycle_ns is 600, 383 or 240 ns. `req_ready` returns to 1 in that same cycle.
- R9: Mode code 3 uses the mode-0 timing.
- R10: `req_valid` and the request fields are ignored while a transfer is in progress.
- R11: On writes, `ata_dout` carries the accepted write data whenever `ata_doe`=1. On reads, `ata_doe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a transfer (taken when `req_ready`=1) |
| req_write | input | 1 | 1 = write to drive, 0 = read |
| req_wide | input | 1 | Requester wants a 16-bit transfer |
| req_mode | input | 2 | Timing mode 0..2 (3 behaves as 0) |
| req_addr | input | ADDR_W | Chip selects and register address for the drive |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Engine idle |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | With `done`: strobe ended by ready timeout |
| xfer_wide | output | 1 | Width used by the last transfer (1 = 16-bit) |
| rdata | output | DATA_W | Last captured read data |
| ata_addr | output | ADDR_W | Address lines to the drive |
| ata_addr_oe | output | 1 | Address lines driven |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | DATA_W | Data lines toward the drive |
| ata_doe | output | 1 | Data lines driven by the host |
| ata_din | input | DATA_W | Data lines from the drive |
| ata_iordy | input | 1 | Drive ready; low stretches the strobe |
| ata_iocs16_n | input | 1 | Drive accepts 16-bit data, active low |

## Verification
Reads and writes run in every mode and in the aliased mode code. This separates the per-mode setup, pulse, hold and cycle counts, and shows which of the hold and the minimum cycle sets the `done` cycle. The 16-bit signal is asserted both early and just after its sample edge, and it is also asserted while the requester asks for 8 bits. This shows that the long pulse and the zeroed upper byte follow the sampled width and not the request alone. The ready line is driven low across the sample edge, low only after it, released before the minimum width, released one edge before the timeout limit, and held low through the limit. The read data changes every cycle, so any capture on the wrong edge gives a value the model does not expect.

// File: rtl/pio_pkg.sv
// Package: shared state type, per-mode nanosecond minimums and the
// rounding helper that turns them into clock counts.
package pio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RECOVER
    } pio_state_t;

    localparam int NUM_MODES = 3;

    // Address-to-strobe lead: the larger of address setup and 16-bit-select valid.
    localparam int LEAD_NS   [NUM_MODES] = '{90, 50, 40};
    localparam int WIDE_NS   [NUM_MODES] = '{165, 125, 100};
    // Trailing hold: the larger of address hold and write data hold.
    localparam int TRAIL_NS  [NUM_MODES] = '{30, 20, 15};
    localparam int PERIOD_NS [NUM_MODES] = '{600, 383, 240};

    localparam int NARROW_NS  = 290;
    localparam int RDY_WIN_NS = 35;
    localparam int STRETCH_NS = 1250;
    // Upper bound on one transfer, used only to size counters.
    localparam int WORST_NS   = 2100;

    // Round a nanosecond minimum up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/pio_mode_timing.sv
// Module: pio_mode_timing
// Turns the per-mode nanosecond minimums into cycle counts for the given
// clock period and selects the set for the latched mode. A code above the
// last mode falls back to mode 0. Assumes CLK_NS is small enough that every
// count is at least 1.
module pio_mode_timing
    import pio_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int CNT_W  = 12
) (
    input  logic [1:0]       mode_sel,
    output logic [CNT_W-1:0] lead_cyc,
    output logic [CNT_W-1:0] wide_cyc,
    output logic [CNT_W-1:0] narrow_cyc,
    output logic [CNT_W-1:0] trail_cyc,
    output logic [CNT_W-1:0] period_cyc,
    output logic [CNT_W-1:0] rdy_cyc,
    output logic [CNT_W-1:0] stretch_cyc
);

    logic [CNT_W-1:0] lead_t   [NUM_MODES];
    logic [CNT_W-1:0] wide_t   [NUM_MODES];
    logic [CNT_W-1:0] trail_t  [NUM_MODES];
    logic [CNT_W-1:0] period_t [NUM_MODES];

    // One set of constant counts per mode.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        assign lead_t[m]   = CNT_W'(ns_to_cyc(LEAD_NS[m],   CLK_NS));
        assign wide_t[m]   = CNT_W'(ns_to_cyc(WIDE_NS[m],   CLK_NS));
        assign trail_t[m]  = CNT_W'(ns_to_cyc(TRAIL_NS[m],  CLK_NS));
        assign period_t[m] = CNT_W'(ns_to_cyc(PERIOD_NS[m], CLK_NS));
    end

    assign narrow_cyc  = CNT_W'(ns_to_cyc(NARROW_NS,  CLK_NS));
    assign rdy_cyc     = CNT_W'(ns_to_cyc(RDY_WIN_NS, CLK_NS));
    assign stretch_cyc = CNT_W'(ns_to_cyc(STRETCH_NS, CLK_NS));

    // Pick the mode's set; unknown codes keep the mode-0 defaults.
    always_comb begin
        lead_cyc   = lead_t[0];
        wide_cyc   = wide_t[0];
        trail_cyc  = trail_t[0];
        period_cyc = period_t[0];
        for (int m = 1; m < NUM_MODES; m++) begin
            if (int'(mode_sel) == m) begin
                lead_cyc   = lead_t[m];
                wide_cyc   = wide_t[m];
                trail_cyc  = trail_t[m];
                period_cyc = period_t[m];
            end
        end
    end

endmodule

// File: rtl/pio_iordy_gate.sv
// Module: pio_iordy_gate
// Decides when the asserted strobe may end. The ready input is looked at once,
// at the end of the sample window. If it is low there, the end waits for
// ready to return high, bounded by the stretch limit counted from that sample.
// Assumes the sample window is shorter than any minimum pulse, and that the
// ready input is already synchronous to clk.
module pio_iordy_gate #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_on,
    input  logic [CNT_W-1:0] phase_cnt,
    input  logic [CNT_W-1:0] pulse_cyc,
    input  logic [CNT_W-1:0] rdy_cyc,
    input  logic [CNT_W-1:0] stretch_cyc,
    input  logic             iordy,
    output logic             end_ok,
    output logic             end_tmo
);

    logic             wait_q;
    logic [CNT_W-1:0] sample_at;
    logic [CNT_W-1:0] limit_at;

    assign sample_at = rdy_cyc - CNT_W'(1);
    assign limit_at  = sample_at + stretch_cyc;

    // Remember a low ready level seen at the sample point of this strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
        end else if (!strobe_on) begin
            wait_q <= 1'b0;
        end else if (phase_cnt == sample_at && !iordy) begin
            wait_q <= 1'b1;
        end
    end

    // Normal end after the minimum width, or forced end at the stretch limit.
    always_comb begin
        end_ok  = strobe_on && (phase_cnt >= pulse_cyc - CNT_W'(1)) && (!wait_q || iordy);
        end_tmo = strobe_on && wait_q && !iordy && (phase_cnt == limit_at);
    end

    // R5: the strobe never outlives the stretch limit.
    p_stretch_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_on |-> phase_cnt <= limit_at);

    // R4: the ready sample falls inside every minimum pulse.
    p_sample_in_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_on |-> rdy_cyc < pulse_cyc);

    // R4: a pending wait only ever follows an asserted strobe.
    p_wait_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_q) |-> $past(strobe_on));

endmodule

// File: rtl/pio_xfer_fsm.sv
// Module: pio_xfer_fsm
// Runs one transfer: setup lead, strobe, trailing hold, then recovery up to
// the mode's minimum cycle. It latches the request, chooses the width at
// strobe assertion, captures read data at negation and pulses done. Assumes
// every cycle count it receives is at least 1.
module pio_xfer_fsm
    import pio_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  lead_cyc,
    input  logic [CNT_W-1:0]  wide_cyc,
    input  logic [CNT_W-1:0]  narrow_cyc,
    input  logic [CNT_W-1:0]  trail_cyc,
    input  logic [CNT_W-1:0]  period_cyc,
    input  logic              end_ok,
    input  logic              end_tmo,
    input  logic [DATA_W-1:0] ata_din,
    input  logic              ata_iocs16_n,
    output logic [1:0]        mode_q,
    output logic              strobe_on,
    output logic [CNT_W-1:0]  phase_cnt,
    output logic [CNT_W-1:0]  pulse_cyc,
    output logic              req_ready,
    output logic              done,
    output logic              timeout,
    output logic              xfer_wide,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ata_addr,
    output logic              ata_addr_oe,
    output logic              ata_rd_n,
    output logic              ata_wr_n,
    output logic [DATA_W-1:0] ata_dout,
    output logic              ata_doe
);

    localparam int HALF_W = DATA_W / 2;

    pio_state_t        state;
    logic [CNT_W-1:0]  tot_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic              want_wide_q;
    logic              tmo_pend;

    assign strobe_on   = (state == ST_STROBE);
    assign pulse_cyc   = xfer_wide ? wide_cyc : narrow_cyc;
    assign req_ready   = (state == ST_IDLE);
    assign ata_addr    = ata_addr_oe ? addr_q : '0;
    assign ata_dout    = ata_doe ? wdata_q : '0;

    // Sequence one transfer and drive the bus-side registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase_cnt   <= '0;
            tot_cnt     <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
            write_q     <= 1'b0;
            want_wide_q <= 1'b0;
            mode_q      <= '0;
            xfer_wide   <= 1'b0;
            tmo_pend    <= 1'b0;
            rdata       <= '0;
            ata_addr_oe <= 1'b0;
            ata_doe     <= 1'b0;
            ata_rd_n    <= 1'b1;
            ata_wr_n    <= 1'b1;
            done        <= 1'b0;
            timeout     <= 1'b0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q      <= req_addr;
                        wdata_q     <= req_wdata;
                        write_q     <= req_write;
                        want_wide_q <= req_wide;
                        mode_q      <= req_mode;
                        tmo_pend    <= 1'b0;
                        ata_addr_oe <= 1'b1;
                        ata_doe     <= req_write;
                        phase_cnt   <= '0;
                        tot_cnt     <= CNT_W'(1);
                        state       <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    tot_cnt <= tot_cnt + CNT_W'(1);
                    if (phase_cnt == lead_cyc - CNT_W'(1)) begin
                        xfer_wide <= want_wide_q && !ata_iocs16_n;
                        ata_rd_n  <= write_q;
                        ata_wr_n  <= !write_q;
                        phase_cnt <= '0;
                        state     <= ST_STROBE;
                    end else begin
                        phase_cnt <= phase_cnt + CNT_W'(1);
                    end
                end
                ST_STROBE: begin
                    tot_cnt <= tot_cnt + CNT_W'(1);
                    if (end_ok || end_tmo) begin
                        ata_rd_n  <= 1'b1;
                        ata_wr_n  <= 1'b1;
                        tmo_pend  <= end_tmo;
                        if (!write_q) begin
                            rdata <= xfer_wide ? ata_din
                                               : {{(DATA_W-HALF_W){1'b0}}, ata_din[HALF_W-1:0]};
                        end
                        phase_cnt <= '0;
                        state     <= ST_HOLD;
                    end else begin
                        phase_cnt <= phase_cnt + CNT_W'(1);
                    end
                end
                ST_HOLD: begin
                    tot_cnt <= tot_cnt + CNT_W'(1);
                    if (phase_cnt == trail_cyc - CNT_W'(1)) begin
                        ata_addr_oe <= 1'b0;
                        ata_doe     <= 1'b0;
                        if (tot_cnt >= period_cyc) begin
                            done    <= 1'b1;
                            timeout <= tmo_pend;
                            state   <= ST_IDLE;
                        end else begin
                            state   <= ST_RECOVER;
                        end
                    end else begin
                        phase_cnt <= phase_cnt + CNT_W'(1);
                    end
                end
                ST_RECOVER: begin
                    tot_cnt <= tot_cnt + CNT_W'(1);
                    if (tot_cnt >= period_cyc) begin
                        done    <= 1'b1;
                        timeout <= tmo_pend;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a strobe is only ever low while the address is driven.
    p_strobe_in_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_rd_n || !ata_wr_n) |-> ata_addr_oe);

    // R2: read and write strobes never overlap.
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));

    // R7, R10: the driven address does not move within a transfer.
    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ata_addr_oe && $past(ata_addr_oe)) |-> $stable(ata_addr));

    // R3: negation never comes before the minimum pulse width.
    p_min_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ata_rd_n & ata_wr_n) |-> $past(phase_cnt) >= $past(pulse_cyc) - CNT_W'(1));

    // R8: done lasts one cycle and never precedes the minimum cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(tot_cnt) >= $past(period_cyc));

    // R5: the error flag only rides on a done pulse.
    p_tmo_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);

    // R11: the data lines are driven only for writes.
    p_doe_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ata_doe |-> write_q);

endmodule

// File: rtl/pio_host_engine.sv
// Module: pio_host_engine
// Top of the programmed-I/O host engine: derives counter widths from the
// clock period, then joins the mode timing table, the ready gate and the
// transfer sequencer. Assumes all drive-side inputs are synchronous to clk.
module pio_host_engine
    import pio_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic              timeout,
    output logic              xfer_wide,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ata_addr,
    output logic              ata_addr_oe,
    output logic              ata_rd_n,
    output logic              ata_wr_n,
    output logic [DATA_W-1:0] ata_dout,
    output logic              ata_doe,
    input  logic [DATA_W-1:0] ata_din,
    input  logic              ata_iordy,
    input  logic              ata_iocs16_n
);

    localparam int CNT_W = $clog2(ns_to_cyc(WORST_NS, CLK_NS) + 2) + 1;

    logic [1:0]       mode_q;
    logic [CNT_W-1:0] lead_cyc, wide_cyc, narrow_cyc, trail_cyc;
    logic [CNT_W-1:0] period_cyc, rdy_cyc, stretch_cyc;
    logic [CNT_W-1:0] phase_cnt, pulse_cyc;
    logic             strobe_on, end_ok, end_tmo;

    pio_mode_timing #(
        .CLK_NS (CLK_NS),
        .CNT_W  (CNT_W)
    ) u_timing (
        .mode_sel    (mode_q),
        .lead_cyc    (lead_cyc),
        .wide_cyc    (wide_cyc),
        .narrow_cyc  (narrow_cyc),
        .trail_cyc   (trail_cyc),
        .period_cyc  (period_cyc),
        .rdy_cyc     (rdy_cyc),
        .stretch_cyc (stretch_cyc)
    );

    pio_iordy_gate #(
        .CNT_W (CNT_W)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_on   (strobe_on),
        .phase_cnt   (phase_cnt),
        .pulse_cyc   (pulse_cyc),
        .rdy_cyc     (rdy_cyc),
        .stretch_cyc (stretch_cyc),
        .iordy       (ata_iordy),
        .end_ok      (end_ok),
        .end_tmo     (end_tmo)
    );

    pio_xfer_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_wide     (req_wide),
        .req_mode     (req_mode),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .lead_cyc     (lead_cyc),
        .wide_cyc     (wide_cyc),
        .narrow_cyc   (narrow_cyc),
        .trail_cyc    (trail_cyc),
        .period_cyc   (period_cyc),
        .end_ok       (end_ok),
        .end_tmo      (end_tmo),
        .ata_din      (ata_din),
        .ata_iocs16_n (ata_iocs16_n),
        .mode_q       (mode_q),
        .strobe_on    (strobe_on),
        .phase_cnt    (phase_cnt),
        .pulse_cyc    (pulse_cyc),
        .req_ready    (req_ready),
        .done         (done),
        .timeout      (timeout),
        .xfer_wide    (xfer_wide),
        .rdata        (rdata),
        .ata_addr     (ata_addr),
        .ata_addr_oe  (ata_addr_oe),
        .ata_rd_n     (ata_rd_n),
        .ata_wr_n     (ata_wr_n),
        .ata_dout     (ata_dout),
        .ata_doe      (ata_doe)
    );

endmodule

// File: tb/pio_host_engine_tb.sv
// Bench: behavioural timeline model of each transfer, compared on every clock.
module pio_host_engine_tb;

    localparam int CLK = 4;
    localparam int AW  = 5;
    localparam int DW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [1:0]    req_mode = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, done, timeout, xfer_wide;
    logic [DW-1:0] rdata, ata_dout;
    logic [AW-1:0] ata_addr;
    logic          ata_addr_oe, ata_rd_n, ata_wr_n, ata_doe;
    logic [DW-1:0] ata_din = '0;
    logic          ata_iordy = 1'b1, ata_iocs16_n = 1'b1;

    int vectors = 0;
    int misses  = 0;
    bit finished = 1'b0;
    logic [DW-1:0] model_rdata = '0;

    always #(CLK/2) clk = ~clk;

    pio_host_engine #(.CLK_NS(CLK), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_mode(req_mode), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .timeout(timeout), .xfer_wide(xfer_wide), .rdata(rdata),
        .ata_addr(ata_addr), .ata_addr_oe(ata_addr_oe), .ata_rd_n(ata_rd_n),
        .ata_wr_n(ata_wr_n), .ata_dout(ata_dout), .ata_doe(ata_doe),
        .ata_din(ata_din), .ata_iordy(ata_iordy), .ata_iocs16_n(ata_iocs16_n)
    );

    function automatic int cyc(input int ns);
        return (ns + CLK - 1) / CLK;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] din_at(input int k, input int seed);
        return DW'(16'h5A00 + k * 37 + seed);
    endfunction

    // One transfer. cs_k: first cycle the 16-bit select is low (before k=0 if <0).
    // Ready is low for cycles k in [lo_s, lo_e). Bogus requests appear at k in [bk, bk+3).
    task automatic run_xfer(input bit wr, input bit wide, input int mode,
                            input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                            input int cs_k, input int lo_s, input int lo_e,
                            input int bk, input int seed);
        int m, s, h, t0, rdy, tmo, p, j, a, d, nend;
        bit wide_e, flag, tmo_e, fin;
        logic [DW-1:0] rd_e;
        m   = (mode == 3) ? 0 : mode;
        s   = cyc(m == 0 ? 90  : m == 1 ? 50  : 40);
        h   = cyc(m == 0 ? 30  : m == 1 ? 20  : 15);
        t0  = cyc(m == 0 ? 600 : m == 1 ? 383 : 240);
        rdy = cyc(35);
        tmo = cyc(1250);
        wide_e = wide && (cs_k <= s - 1);
        p = wide_e ? cyc(m == 0 ? 165 : m == 1 ? 125 : 100) : cyc(290);
        flag  = (s + rdy - 1 >= lo_s) && (s + rdy - 1 < lo_e);
        tmo_e = 1'b0;
        nend  = s + p;
        if (flag) begin
            fin = 1'b0;
            for (int jj = s + p; jj <= s + rdy + tmo && !fin; jj++) begin
                if (!((jj - 1 >= lo_s) && (jj - 1 < lo_e))) begin
                    nend = jj; fin = 1'b1;
                end else if (jj == s + rdy + tmo) begin
                    nend = jj; fin = 1'b1; tmo_e = 1'b1;
                end
            end
        end
        j = nend;
        a = j + h;
        d = (a > t0) ? a : t0;
        rd_e = din_at(j - 1, seed);
        if (!wide_e) rd_e[DW-1:DW/2] = '0;

        // Present the request in an idle cycle.
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide; req_mode = 2'(mode);
        req_addr = addr; req_wdata = wd;
        ata_iocs16_n = !(cs_k < 0);
        ata_iordy = 1'b1;
        for (int k = 0; k <= d; k++) begin
            @(negedge clk);
            chk("R8", "req_ready", req_ready, k >= d);
            chk("R8", "done", done, k == d);
            chk("R5", "timeout", timeout, (k == d) && tmo_e);
            chk("R7", "ata_addr_oe", ata_addr_oe, k < a);
            if (k < a) chk("R10", "ata_addr", ata_addr, addr);
            chk("R2", "ata_rd_n", ata_rd_n, !(!wr && k >= s && k < j));
            chk("R4", "ata_wr_n", ata_wr_n, !(wr && k >= s && k < j));
            chk("R11", "ata_doe", ata_doe, wr && k < a);
            if (wr && k < a) chk("R11", "ata_dout", ata_dout, wd);
            if (!wr && k >= j) chk("R6", "rdata", rdata, rd_e);
            if (wr && k == d)  chk("R6", "rdata kept", rdata, model_rdata);
            if (k == d) chk("R3", "xfer_wide", xfer_wide, wide_e);
            // Drive the inputs seen at the next edge.
            ata_iocs16_n = !(k >= cs_k);
            ata_iordy    = !((k >= lo_s) && (k < lo_e));
            ata_din      = din_at(k, seed);
            if (k >= bk && k < bk + 3 && k < d) begin
                req_valid = 1'b1; req_addr = addr ^ '1; req_write = !wr; req_wdata = ~wd;
                req_mode = 2'd2;
            end else begin
                req_valid = 1'b0;
            end
        end
        if (!wr) model_rdata = rd_e;
        ata_iordy = 1'b1; ata_iocs16_n = 1'b1; req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held at the idle state during reset.
        chk("R1", "ready in reset", req_ready, 1);
        chk("R1", "rd_n in reset", ata_rd_n, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "ata_rd_n", ata_rd_n, 1);
        chk("R1", "ata_wr_n", ata_wr_n, 1);
        chk("R1", "ata_addr_oe", ata_addr_oe, 0);
        chk("R1", "ata_doe", ata_doe, 0);
        chk("R1", "done", done, 0);
        chk("R1", "timeout", timeout, 0);

        // R2 R3 R6: 16-bit read, mode 2, select low early.
        run_xfer(0, 1, 2, 5'h10, 16'h0000, -1, 1000, 1000, 1000, 1);
        // R3: select arrives after its sample edge, so 8-bit with upper byte zero.
        run_xfer(0, 1, 2, 5'h11, 16'h0000, 20, 1000, 1000, 1000, 2);
        // R11 R7: 16-bit write, mode 1.
        run_xfer(1, 1, 1, 5'h08, 16'hBEEF, -1, 1000, 1000, 1000, 3);
        // R3: narrow request with select asserted stays 8-bit, mode 0.
        run_xfer(1, 0, 0, 5'h09, 16'h1234, -1, 1000, 1000, 1000, 4);
        // R9: mode code 3 behaves as mode 0.
        run_xfer(0, 1, 3, 5'h0A, 16'h0000, -1, 1000, 1000, 1000, 5);
        // R4: ready low at the sample, released after the minimum width.
        run_xfer(0, 1, 2, 5'h12, 16'h0000, -1, 12, 60, 1000, 6);
        // R4: ready low only after the sample edge is ignored.
        run_xfer(1, 1, 1, 5'h13, 16'h5555, -1, 30, 40, 1000, 7);
        // R4: ready low at the sample but back high before the minimum width.
        run_xfer(0, 1, 2, 5'h14, 16'h0000, -1, 15, 22, 1000, 8);
        // R5: release one edge before the limit gives a normal end.
        run_xfer(0, 1, 2, 5'h15, 16'h0000, -1, 5, 331, 1000, 9);
        // R5: ready held low through the limit gives a timeout.
        run_xfer(0, 1, 2, 5'h16, 16'h0000, -1, 5, 100000, 1000, 10);
        // R10: requests raised mid-transfer are ignored.
        run_xfer(0, 1, 2, 5'h17, 16'h0000, -1, 1000, 1000, 5, 11);
        // R6: write after read keeps rdata.
        run_xfer(1, 1, 2, 5'h18, 16'hA5A5, -1, 1000, 1000, 1000, 12);
        repeat (3) @(negedge clk);
        chk("R8", "idle after run", req_ready, 1);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule